// File: doc/BRIEF.md
# Shared-Register Interrupt Aggregator

This block merges up to sixteen interrupt source lines into a single level-sensitive parent interrupt. Each source position has a sticky pending flag, which is set while its input is high and cleared by software writing a one to it. It also has an enable flag that decides whether that pending flag drives the parent line. Software reaches both through a plain 32-bit register port with an address, a write strobe, write data and combinational read data.

A parameter selects one of two register layouts. In the combined layout, a single word at offset 0x0 carries the enables in its low half and the pending flags sixteen positions higher. A read-modify-write of the enables that puts zeros in the pending field therefore never loses a pending event. In the split layout, the enables and the pending flags sit in two separate words at offsets 0x0 and 0x4, and a parameter chooses which offset holds which word. Two more parameters implement only a contiguous window of source positions, given as a start position and a count. All other positions are absent.

Top module: `irq_share_agg`

## Requirements
- R1: After synchronous reset, all enable and pending flags are zero, every read returns zero and `irq_o` is low.
- R2: In the combined layout (`SPLIT_LAYOUT`=0), the word at offset 0x0 holds the enable of position n at bit n and its pending flag at bit n+16. Because the pending field spans bits 28..16, the window is limited to positions 0..12.
- R3: A pending flag is set on every clock in which its source input is high. When a set and a write-1 clear hit the same flag in the same cycle, the flag stays set.
- R4: Writing 1 to a pending position clears it. Writing 0 to a pending position leaves it unchanged. Enable bits in the same write take the written value.
- R5: In the split layout, one word holds the enables in bits 15..0 and the other holds the pending flags in bits 15..0, with upper bits reading zero. The enable word is at offset 0x4 when `EN_AT_OFS4`=1 and at 0x0 otherwise, and the pending word is at the other offset.
- R6: In the split layout, writing all ones to the pending word clears every pending flag.
- R7: Only the positions `WIN_LO`..`WIN_LO+WIN_CNT-1` exist. Enable and pending bits outside that window read as zero and ignore writes, and source inputs outside it have no effect.
- R8: `irq_o` is a registered OR of (pending AND enabled). It rises the cycle after such a pair appears and falls the cycle after the last one goes away.
- R9: Clearing an enable removes that source from `irq_o` but keeps its pending flag.
- R10: Offsets other than the implemented words read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 16 | Source lines, indexed by position |
| addr_i | input | ADDR_W | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Registered parent interrupt |

## Verification
On every cycle, the assertions check the following: a source that was high leaves its flag set, a written one clears a flag unless a source sets it again, a written zero never clears a flag, an enable write lands exactly, `irq_o` tracks the previous cycle's pending-and-enabled state, and unimplemented read bits stay zero. Only the bench scenarios can show the address map itself. That includes which offset holds which word in each layout, that unmapped offsets swallow writes, the masking sequence that keeps a flag pending while dropping the parent line, and the all-ones clear of the split layout. Two instances, one per layout, run under the same stimulus.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int SRC_W      = 16;
    localparam int DATA_W     = 32;
    localparam int PEND_SHIFT = 16;
    localparam int COMB_MAX   = 13;

    typedef logic [SRC_W-1:0]  srcvec_t;
    typedef logic [DATA_W-1:0] word_t;

    // Register side effects of one access, already masked to the window
    typedef struct packed {
        logic    en_we;
        srcvec_t en_val;
        srcvec_t clr;
    } reg_cmd_t;

    function automatic srcvec_t win_mask(input int lo, input int cnt);
        srcvec_t m;
        m = '0;
        for (int i = 0; i < SRC_W; i++) begin
            if (i >= lo && i < lo + cnt) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irqagg_pending.sv
module irqagg_pending
    import irqagg_pkg::*;
#(
    parameter srcvec_t WIN = 16'h007F
) (
    input  logic    clk,
    input  logic    rst,
    input  srcvec_t src_i,
    input  srcvec_t clr_i,
    output srcvec_t pend_o
);

    srcvec_t set_w;
    assign set_w = src_i & WIN;

    for (genvar i = 0; i < SRC_W; i++) begin : g_pos
        if (WIN[i]) begin : g_live
            logic flag_q;
            always_ff @(posedge clk) begin
                if (rst)
                    flag_q <= 1'b0;
                else if (set_w[i])
                    flag_q <= 1'b1;
                else if (clr_i[i])
                    flag_q <= 1'b0;
            end
            assign pend_o[i] = flag_q;
        end else begin : g_absent
            assign pend_o[i] = 1'b0;
        end
    end

    // R3: a source seen high leaves its flag set, even against a clear
    p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_o & $past(set_w)) == $past(set_w)));

    // R4: a written zero never clears a flag
    p_zero_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(pend_o) & ~$past(clr_i)) & ~pend_o) == '0));

    // R4: a written one clears the flag when no source sets it
    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_o & $past(clr_i) & ~$past(set_w)) == '0));

    // R7: positions outside the window never hold a flag
    p_outside_r7: assert property (@(posedge clk) disable iff (rst)
        (pend_o & ~WIN) == '0);

endmodule

// File: rtl/irqagg_decode.sv
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter bit      SPLIT_LAYOUT = 1'b0,
    parameter bit      EN_AT_OFS4   = 1'b0,
    parameter srcvec_t WIN          = 16'h007F,
    parameter int      ADDR_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  word_t             wr_data_i,
    input  srcvec_t           en_q_i,
    input  srcvec_t           pend_q_i,
    output reg_cmd_t          cmd_o,
    output word_t             rd_data_o
);

    localparam logic [ADDR_W-1:0] OFS_LO = '0;
    localparam logic [ADDR_W-1:0] OFS_HI = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_EN = EN_AT_OFS4 ? OFS_HI : OFS_LO;
    localparam logic [ADDR_W-1:0] OFS_ST = EN_AT_OFS4 ? OFS_LO : OFS_HI;

    if (!SPLIT_LAYOUT) begin : g_comb
        always_comb begin
            cmd_o     = '0;
            rd_data_o = '0;
            if (addr_i == OFS_LO) begin
                rd_data_o = {pend_q_i, en_q_i};
                if (wr_en_i) begin
                    cmd_o.en_we  = 1'b1;
                    cmd_o.en_val = wr_data_i[SRC_W-1:0] & WIN;
                    cmd_o.clr    = wr_data_i[DATA_W-1:PEND_SHIFT] & WIN;
                end
            end
        end
    end else begin : g_split
        logic unused_hi;
        assign unused_hi = ^wr_data_i[DATA_W-1:SRC_W];
        always_comb begin
            cmd_o     = '0;
            rd_data_o = '0;
            if (addr_i == OFS_EN) begin
                rd_data_o = {{(DATA_W-SRC_W){1'b0}}, en_q_i};
                if (wr_en_i) begin
                    cmd_o.en_we  = 1'b1;
                    cmd_o.en_val = wr_data_i[SRC_W-1:0] & WIN;
                end
            end else if (addr_i == OFS_ST) begin
                rd_data_o = {{(DATA_W-SRC_W){1'b0}}, pend_q_i};
                if (wr_en_i) cmd_o.clr = wr_data_i[SRC_W-1:0] & WIN;
            end
        end
    end

    // R7: read bits of absent positions are zero
    p_rd_unused_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_data_o & ~{WIN, WIN}) == '0);

    // R10: a write that hits no implemented word produces no side effect
    p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
        (addr_i != OFS_LO && addr_i != OFS_HI) |-> (cmd_o == '0 && rd_data_o == '0));

endmodule

// File: rtl/irq_share_agg.sv
module irq_share_agg
    import irqagg_pkg::*;
#(
    parameter bit SPLIT_LAYOUT = 1'b0,
    parameter bit EN_AT_OFS4   = 1'b0,
    parameter int WIN_LO       = 0,
    parameter int WIN_CNT      = 7,
    parameter int ADDR_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       src_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [31:0]       wr_data_i,
    output logic [31:0]       rd_data_o,
    output logic              irq_o
);

    localparam srcvec_t WIN = win_mask(WIN_LO, WIN_CNT);

    if (!SPLIT_LAYOUT && (WIN_LO + WIN_CNT > COMB_MAX)) begin : g_bad_window
        $error("combined layout allows positions 0..12 only");
    end

    reg_cmd_t cmd;
    srcvec_t  en_q;
    srcvec_t  pend;
    logic     irq_q;

    irqagg_decode #(
        .SPLIT_LAYOUT(SPLIT_LAYOUT),
        .EN_AT_OFS4  (EN_AT_OFS4),
        .WIN         (WIN),
        .ADDR_W      (ADDR_W)
    ) u_decode (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .en_q_i    (en_q),
        .pend_q_i  (pend),
        .cmd_o     (cmd),
        .rd_data_o (rd_data_o)
    );

    irqagg_pending #(
        .WIN(WIN)
    ) u_pending (
        .clk    (clk),
        .rst    (rst),
        .src_i  (src_i),
        .clr_i  (cmd.clr),
        .pend_o (pend)
    );

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (cmd.en_we)
            en_q <= cmd.en_val;
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |(pend & en_q);
    end

    assign irq_o = irq_q;

    // R8: parent line follows last cycle's pending-and-enabled state
    p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(|(pend & en_q))));

    // R4: an enable write lands exactly as written within the window
    p_en_write_r4: assert property (@(posedge clk) disable iff (rst)
        cmd.en_we |=> (en_q == ($past(wr_data_i[15:0]) & WIN)));

    // R9: without an enable write the enables do not move
    p_en_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !cmd.en_we |=> $stable(en_q));

endmodule

// File: tb/irq_share_agg_tb_top.sv
`timescale 1ns/1ps
module irq_share_agg_tb_top;

    localparam int CLO = 2, CCNT = 7;
    localparam int SLO = 4, SCNT = 10;
    localparam logic [15:0] CWIN = 16'(((1 << CCNT) - 1) << CLO);
    localparam logic [15:0] SWIN = 16'(((1 << SCNT) - 1) << SLO);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src = '0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rd_c, rd_s;
    logic        irq_c, irq_s;

    int total = 0;
    int bad   = 0;
    string tag = "R1";

    logic [15:0] mc_en, mc_pend, ms_en, ms_pend;
    logic        mc_irq, ms_irq;

    always #2.5 clk = ~clk;

    irq_share_agg #(.SPLIT_LAYOUT(1'b0), .EN_AT_OFS4(1'b0), .WIN_LO(CLO), .WIN_CNT(CCNT), .ADDR_W(4)) dut_i (
        .clk(clk), .rst(rst), .src_i(src), .addr_i(addr), .wr_en_i(we),
        .wr_data_i(wd), .rd_data_o(rd_c), .irq_o(irq_c));

    irq_share_agg #(.SPLIT_LAYOUT(1'b1), .EN_AT_OFS4(1'b1), .WIN_LO(SLO), .WIN_CNT(SCNT), .ADDR_W(4)) dut_split_i (
        .clk(clk), .rst(rst), .src_i(src), .addr_i(addr), .wr_en_i(we),
        .wr_data_i(wd), .rd_data_o(rd_s), .irq_o(irq_s));

    function automatic logic [31:0] exp_rd_c(input logic [3:0] a);
        return (a == 4'h0) ? {mc_pend, mc_en} : 32'h0;
    endfunction

    function automatic logic [31:0] exp_rd_s(input logic [3:0] a);
        if (a == 4'h4) return {16'h0, ms_en};
        if (a == 4'h0) return {16'h0, ms_pend};
        return 32'h0;
    endfunction

    task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(tag, "comb rd", rd_c, exp_rd_c(addr));
        chk(tag, "split rd", rd_s, exp_rd_s(addr));
        chk(tag, "comb irq", {31'h0, irq_c}, {31'h0, mc_irq});
        chk(tag, "split irq", {31'h0, irq_s}, {31'h0, ms_irq});
    endtask

    task automatic step(input logic [3:0] a, input logic w, input logic [31:0] d, input logic [15:0] s);
        logic [15:0] cen, cclr, sen, sclr;
        logic        ci, si;
        @(negedge clk);
        compare_all();
        addr = a; we = w; wd = d; src = s;
        ci = |(mc_pend & mc_en);
        si = |(ms_pend & ms_en);
        cen = mc_en; cclr = '0; sen = ms_en; sclr = '0;
        if (w && a == 4'h0) begin
            cen  = d[15:0] & CWIN;
            cclr = d[31:16] & CWIN;
        end
        if (w && a == 4'h4) sen  = d[15:0] & SWIN;
        if (w && a == 4'h0) sclr = d[15:0] & SWIN;
        @(posedge clk);
        mc_pend = (mc_pend & ~cclr) | (s & CWIN);
        ms_pend = (ms_pend & ~sclr) | (s & SWIN);
        mc_en = cen; ms_en = sen; mc_irq = ci; ms_irq = si;
    endtask

    // Directed check sampled 1 ns after the edge that ends the last step
    task automatic expect_now(input string t, input logic [31:0] ec, input logic [31:0] es);
        #1;
        chk(t, "comb rd directed", rd_c, ec);
        chk(t, "split rd directed", rd_s, es);
    endtask

    task automatic expect_irq(input string t, input logic ec, input logic es);
        #1;
        chk(t, "comb irq directed", {31'h0, irq_c}, {31'h0, ec});
        chk(t, "split irq directed", {31'h0, irq_s}, {31'h0, es});
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        mc_en = '0; mc_pend = '0; ms_en = '0; ms_pend = '0; mc_irq = 1'b0; ms_irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        tag = "R1";
        step(4'h0, 1'b0, 32'h0, 16'h0);
        expect_now("R1", 32'h0, 32'h0);
        expect_irq("R1", 1'b0, 1'b0);

        // R2 / R7: combined enables land only inside positions 2..8
        tag = "R2";
        step(4'h0, 1'b1, 32'h0000FFFF, 16'h0);
        expect_now("R2", 32'h000001FC, 32'h0);

        // R5: split enable word at 0x4, window 4..13; combined reads 0 there (R10)
        tag = "R5";
        step(4'h4, 1'b1, 32'h0000FFFF, 16'h0);
        expect_now("R5", 32'h0, 32'h00003FF0);

        // R3: sources 2 and 4 set flags
        tag = "R3";
        step(4'h0, 1'b0, 32'h0, 16'h0014);
        expect_now("R3", 32'h001401FC, 32'h00000010);
        expect_irq("R8", 1'b0, 1'b0);
        tag = "R8";
        step(4'h0, 1'b0, 32'h0, 16'h0);
        expect_irq("R8", 1'b1, 1'b1);

        // R4: zeros in the pending field keep flags
        tag = "R4";
        step(4'h0, 1'b1, 32'h000001FC, 16'h0);
        expect_now("R4", 32'h001401FC, 32'h0);

        // R9: masking keeps pending, parent falls one cycle later
        tag = "R9";
        step(4'h0, 1'b1, 32'h00000000, 16'h0);
        expect_now("R9", 32'h00140000, 32'h0);
        step(4'h0, 1'b0, 32'h0, 16'h0);
        expect_irq("R9", 1'b0, 1'b0);

        // R3: set beats clear in the same cycle
        tag = "R3";
        step(4'h0, 1'b1, 32'h00040000, 16'h0004);
        expect_now("R3", 32'h00140000, 32'h0);

        // R4: write-1 clears
        tag = "R4";
        step(4'h0, 1'b1, 32'h00140000, 16'h0);
        expect_now("R4", 32'h0, 32'h0);

        // R7: sources outside both windows are ignored
        tag = "R7";
        step(4'h0, 1'b0, 32'h0, 16'hC003);
        expect_now("R7", 32'h0, 32'h0);

        // R6: all-ones write to split pending word clears everything
        tag = "R6";
        step(4'h0, 1'b0, 32'h0, 16'h3FF0);
        expect_now("R6", 32'h01F00000, 32'h00003FF0);
        step(4'h0, 1'b1, 32'hFFFFFFFF, 16'h0);
        expect_now("R6", 32'h000001FC, 32'h0);

        // R10: unmapped offsets read zero and swallow writes
        tag = "R10";
        step(4'h8, 1'b1, 32'hFFFFFFFF, 16'h0);
        expect_now("R10", 32'h0, 32'h0);
        step(4'h1, 1'b1, 32'hFFFFFFFF, 16'h0);
        expect_now("R10", 32'h0, 32'h0);
        step(4'h0, 1'b0, 32'h0, 16'h0);
        expect_now("R10", 32'h000001FC, 32'h0);
        step(4'h4, 1'b0, 32'h0, 16'h0);
        expect_now("R10", 32'h0, 32'h00003FF0);

        // Mixed traffic against the reference model
        tag = "R8";
        for (int i = 0; i < 600; i++) begin
            logic [3:0] a;
            case ($urandom % 4)
                0: a = 4'h0;
                1: a = 4'h4;
                2: a = 4'h8;
                default: a = 4'h1;
            endcase
            step(a, ($urandom % 3) == 0, $urandom,
                 16'($urandom) & 16'($urandom) & 16'($urandom));
        end

        // R1: reset in mid-run clears everything
        tag = "R1";
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        mc_en = '0; mc_pend = '0; ms_en = '0; ms_pend = '0; mc_irq = 1'b0; ms_irq = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        addr = 4'h0; we = 1'b0; src = '0;
        step(4'h0, 1'b0, 32'h0, 16'h0);
        expect_now("R1", 32'h0, 32'h0);
        expect_irq("R1", 1'b0, 1'b0);
        step(4'h0, 1'b0, 32'h0, 16'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule